// File: doc/BRIEF.md
# Snooping MESI Coherence Engine

This block keeps a handful of small private caches coherent over one shared snoop bus. Each core owns a direct-mapped cache of a few 64-byte lines, and every line carries one of four coherence states. A core posts a read, a write or an eviction as a single-cycle request pulse. A round-robin arbiter picks one pending request at a time. The engine then performs the whole bus transaction in one commit cycle: lookup, snoop of every other cache, cache-to-cache supply, writebacks to the internal backing memory, and the state updates in all caches.

When the transaction completes, the requester's bit of `doneVec` pulses for one cycle. In that cycle the response outputs carry the hit flag, the requester's resulting line state, the addressed word and the resulting state of that address in every cache. A core must wait for its done pulse before it posts its next request. The backing memory comes out of reset cleared to zero.

Top module: `mesi_coherence`

## Requirements
- R1: State fields use Invalid=0, Shared=1, Exclusive=2, Modified=3. Ops use read=0, write=1, evict=2. Addresses are word addresses made of {tag, index, 4-bit word}. After reset every line is Invalid, and the requester's field in `peerStates` equals `respState` on each done pulse.
- R2: A read miss that no other cache holds is filled from memory and installed as Exclusive.
- R3: A read miss on a line that other caches hold in Exclusive or Shared takes the data from memory. The requester and those holders all end Shared.
- R4: A write to a Shared line reports a hit, invalidates every other copy and leaves the writer Modified with the new word.
- R5: A write to an Exclusive line reports a hit and moves it to Modified, with no change to any other cache.
- R6: When a cache holds an address Modified, every other cache's copy of that address is Invalid.
- R7: Evicting a held line reports a hit and leaves it Invalid. A Modified line is written back to memory first, and a clean line is dropped.
- R8: A snooped read or write that finds another cache holding the line Modified takes that cache's data and writes it to memory. The supplier ends Shared after a read and Invalid after a write.
- R9: Coherence works on whole 64-byte lines. A write to one word of a line invalidates other caches that hold any word of that line.
- R10: Requests are served one at a time, in round-robin order. Exactly one done bit pulses per transaction, only for a core that has a request outstanding. Four simultaneous requests all finish within 10 cycles.
- R11: A read hit returns the cached word and changes no state in any cache.
- R12: Evicting an address the requester does not hold reports a miss, returns Invalid and changes no cache.
- R13: A miss whose victim line is Modified writes the victim back, even when a remote Modified copy is written back in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NCORES | One-cycle request pulse per core |
| reqOp | input | 2*NCORES | Per-core operation code |
| reqAddr | input | NCORES*AW | Per-core word address |
| reqData | input | NCORES*DW | Per-core write word |
| doneVec | output | NCORES | One-hot completion pulse |
| respHit | output | 1 | Requester already held the line |
| respState | output | 2 | Requester's resulting state |
| respData | output | DW | Addressed word after the operation |
| peerStates | output | 2*NCORES | Resulting state of the address in each cache |

## Verification
The hardest overlap is a miss whose victim line is dirty while a different cache holds the requested line Modified. Two writebacks to different memory lines then land in the same commit cycle. The bench builds this case by making core 0 dirty in one line and core 2 dirty in a conflicting line, and then has core 0 read core 2's line. Later cold reads by other cores return both written values from memory, which shows that both writebacks landed. A second overlap, four requests raised in the same cycle, is judged by one-hot completion and by all four finishing inside the round-robin bound.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } mesi_t;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2
  } op_t;

  // strobes from control to datapath for the committing transaction
  typedef struct packed {
    logic commit;
    logic isRead;
    logic isWrite;
    logic isEvict;
  } dp_strb_t;
endpackage

// File: rtl/mesi_ctrl.sv
module mesi_ctrl
  import mesi_pkg::*;
#(
  parameter int NCORES = 4,
  parameter int AW     = 8,
  parameter int DW     = 32,
  localparam int CW    = $clog2(NCORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCORES-1:0]    reqValid,
  input  logic [2*NCORES-1:0]  reqOp,
  input  logic [NCORES*AW-1:0] reqAddr,
  input  logic [NCORES*DW-1:0] reqData,
  output dp_strb_t             strb,
  output logic [CW-1:0]        grantIdx,
  output logic [AW-1:0]        selAddr,
  output logic [DW-1:0]        selData
);
  logic [NCORES-1:0] pend;
  logic [1:0]        pendOp   [NCORES];
  logic [AW-1:0]     pendAddr [NCORES];
  logic [DW-1:0]     pendData [NCORES];
  logic [CW-1:0]     rrPtr, winIdx;
  logic              winFound, execPhase;
  logic [1:0]        selOp;

  // round-robin pick starting at rrPtr
  always_comb begin
    int k;
    winFound = 1'b0;
    winIdx   = '0;
    for (int off = 0; off < NCORES; off++) begin
      k = (int'(rrPtr) + off) % NCORES;
      if (!winFound && pend[k]) begin
        winFound = 1'b1;
        winIdx   = CW'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend      <= '0;
      rrPtr     <= '0;
      execPhase <= 1'b0;
      grantIdx  <= '0;
      selOp     <= '0;
      selAddr   <= '0;
      selData   <= '0;
      for (int i = 0; i < NCORES; i++) begin
        pendOp[i]   <= '0;
        pendAddr[i] <= '0;
        pendData[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCORES; i++) begin
        if (reqValid[i]) begin
          pend[i]     <= 1'b1;
          pendOp[i]   <= reqOp[2*i +: 2];
          pendAddr[i] <= reqAddr[i*AW +: AW];
          pendData[i] <= reqData[i*DW +: DW];
        end
      end
      if (execPhase) begin
        execPhase <= 1'b0;
      end else if (winFound) begin
        execPhase      <= 1'b1;
        pend[winIdx]   <= 1'b0;
        grantIdx       <= winIdx;
        selOp          <= pendOp[winIdx];
        selAddr        <= pendAddr[winIdx];
        selData        <= pendData[winIdx];
        rrPtr          <= (int'(winIdx) == NCORES - 1) ? '0 : winIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.commit  = execPhase;
    strb.isRead  = execPhase && (selOp == OP_READ);
    strb.isWrite = execPhase && (selOp == OP_WRITE);
    strb.isEvict = execPhase && (selOp == OP_EVICT);
  end
endmodule

// File: rtl/mesi_dp.sv
module mesi_dp
  import mesi_pkg::*;
#(
  parameter int NCORES     = 4,
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 16,
  localparam int CW        = $clog2(NCORES),
  localparam int OFFW      = $clog2(LINE_WORDS),
  localparam int IDXW      = $clog2(LINES),
  localparam int TAGW      = AW - OFFW - IDXW,
  localparam int MLW       = AW - OFFW,
  localparam int MEMLINES  = 2 ** MLW,
  localparam int LINEW     = LINE_WORDS * DW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dp_strb_t             strb,
  input  logic [CW-1:0]        grantIdx,
  input  logic [AW-1:0]        selAddr,
  input  logic [DW-1:0]        selData,
  output logic [NCORES-1:0]    doneVec,
  output logic                 respHit,
  output logic [1:0]           respState,
  output logic [DW-1:0]        respData,
  output logic [2*NCORES-1:0]  peerStates
);
  logic [LINEW-1:0] cData [NCORES][LINES];
  logic [TAGW-1:0]  cTag  [NCORES][LINES];
  mesi_t            cSt   [NCORES][LINES];
  logic [LINEW-1:0] mem   [MEMLINES];

  logic [IDXW-1:0]   idx;
  logic [TAGW-1:0]   tag;
  logic [OFFW-1:0]   word;
  logic [MLW-1:0]    memIdx, victimIdx;
  logic [NCORES-1:0] hold;
  logic              otherHold, ownerFound, ownHold, victimDirty;
  logic [LINEW-1:0]  ownerLine, ownLine, newLine;
  mesi_t             ownSt, newOwnSt;
  mesi_t             peerNext [NCORES];

  assign idx       = selAddr[OFFW +: IDXW];
  assign tag       = selAddr[AW-1 -: TAGW];
  assign word      = selAddr[OFFW-1:0];
  assign memIdx    = selAddr[AW-1:OFFW];
  assign ownSt     = cSt[grantIdx][idx];
  assign ownLine   = cData[grantIdx][idx];
  assign ownHold   = hold[grantIdx];
  assign victimIdx = {cTag[grantIdx][idx], idx};
  assign victimDirty = !ownHold && (ownSt == ST_M);

  // snoop every cache for the addressed line
  always_comb begin
    otherHold  = 1'b0;
    ownerFound = 1'b0;
    ownerLine  = '0;
    for (int k = 0; k < NCORES; k++) begin
      hold[k] = (cSt[k][idx] != ST_I) && (cTag[k][idx] == tag);
      if (hold[k] && CW'(k) != grantIdx) begin
        otherHold = 1'b1;
        if (cSt[k][idx] == ST_M) begin
          ownerFound = 1'b1;
          ownerLine  = cData[k][idx];
        end
      end
    end
  end

  always_comb begin
    newLine = ownHold ? ownLine : (ownerFound ? ownerLine : mem[memIdx]);
    if (strb.isWrite) newLine[word*DW +: DW] = selData;
    if (strb.isEvict)      newOwnSt = ST_I;
    else if (strb.isWrite) newOwnSt = ST_M;
    else if (ownHold)      newOwnSt = ownSt;
    else                   newOwnSt = otherHold ? ST_S : ST_E;
    for (int k = 0; k < NCORES; k++) begin
      if (CW'(k) == grantIdx)  peerNext[k] = newOwnSt;
      else if (!hold[k])       peerNext[k] = ST_I;
      else if (strb.isWrite)   peerNext[k] = ST_I;
      else if (strb.isRead)    peerNext[k] = ST_S;
      else                     peerNext[k] = cSt[k][idx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 0; k < NCORES; k++)
        for (int l = 0; l < LINES; l++) begin
          cSt[k][l]   <= ST_I;
          cTag[k][l]  <= '0;
          cData[k][l] <= '0;
        end
      for (int m = 0; m < MEMLINES; m++) mem[m] <= '0;
      doneVec    <= '0;
      respHit    <= 1'b0;
      respState  <= '0;
      respData   <= '0;
      peerStates <= '0;
    end else begin
      doneVec <= '0;
      if (strb.commit) begin
        for (int k = 0; k < NCORES; k++)
          if (CW'(k) != grantIdx && hold[k]) cSt[k][idx] <= peerNext[k];
        if (strb.isEvict) begin
          if (ownHold) cSt[grantIdx][idx] <= ST_I;
          if (ownHold && ownSt == ST_M) mem[memIdx] <= ownLine;
        end else begin
          cSt[grantIdx][idx]   <= newOwnSt;
          cTag[grantIdx][idx]  <= tag;
          cData[grantIdx][idx] <= newLine;
          if (ownerFound)  mem[memIdx]    <= ownerLine;
          if (victimDirty) mem[victimIdx] <= ownLine;
        end
        doneVec[grantIdx] <= 1'b1;
        respHit   <= ownHold;
        respState <= newOwnSt;
        respData  <= strb.isEvict ? '0 : newLine[word*DW +: DW];
        for (int k = 0; k < NCORES; k++) peerStates[2*k +: 2] <= peerNext[k];
      end
    end
  end
endmodule

// File: rtl/mesi_coherence.sv
module mesi_coherence
  import mesi_pkg::*;
#(
  parameter int NCORES     = 4,
  parameter int AW         = 8,
  parameter int DW         = 32,
  parameter int LINES      = 4,
  parameter int LINE_WORDS = 16,
  localparam int CW        = $clog2(NCORES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NCORES-1:0]    reqValid,
  input  logic [2*NCORES-1:0]  reqOp,
  input  logic [NCORES*AW-1:0] reqAddr,
  input  logic [NCORES*DW-1:0] reqData,
  output logic [NCORES-1:0]    doneVec,
  output logic                 respHit,
  output logic [1:0]           respState,
  output logic [DW-1:0]        respData,
  output logic [2*NCORES-1:0]  peerStates
);
  dp_strb_t      strb;
  logic [CW-1:0] grantIdx;
  logic [AW-1:0] selAddr;
  logic [DW-1:0] selData;

  mesi_ctrl #(.NCORES(NCORES), .AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .strb(strb),
    .grantIdx(grantIdx), .selAddr(selAddr), .selData(selData)
  );

  mesi_dp #(.NCORES(NCORES), .AW(AW), .DW(DW), .LINES(LINES),
            .LINE_WORDS(LINE_WORDS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .grantIdx(grantIdx),
    .selAddr(selAddr), .selData(selData), .doneVec(doneVec),
    .respHit(respHit), .respState(respState), .respData(respData),
    .peerStates(peerStates)
  );
endmodule

// File: rtl/mesi_checker.sv
module mesi_checker #(
  parameter int NCORES = 4,
  parameter int DW     = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic [NCORES-1:0]   reqValid,
  input logic [2*NCORES-1:0] reqOp,
  input logic [NCORES-1:0]   doneVec,
  input logic                respHit,
  input logic [1:0]          respState,
  input logic [DW-1:0]       respData,
  input logic [2*NCORES-1:0] peerStates
);
  logic [NCORES-1:0] outstanding;
  logic [1:0]        lastOp [NCORES];
  logic [1:0]        doneOp, selfField;
  logic              anyDone;
  int                modCount, liveCount;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding <= '0;
      for (int i = 0; i < NCORES; i++) lastOp[i] <= '0;
    end else begin
      for (int i = 0; i < NCORES; i++) begin
        if (reqValid[i]) begin
          outstanding[i] <= 1'b1;
          lastOp[i]      <= reqOp[2*i +: 2];
        end else if (doneVec[i]) begin
          outstanding[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    anyDone   = |doneVec;
    doneOp    = '0;
    selfField = '0;
    modCount  = 0;
    liveCount = 0;
    for (int i = 0; i < NCORES; i++) begin
      if (doneVec[i]) begin
        doneOp    = lastOp[i];
        selfField = peerStates[2*i +: 2];
      end
      if (peerStates[2*i +: 2] == 2'd3) modCount++;
      if (peerStates[2*i +: 2] != 2'd0) liveCount++;
    end
  end

  assert_single_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(doneVec));

  for (genvar g = 0; g < NCORES; g++) begin : g_req
    assert_done_has_request_R10: assert property (@(posedge clk) disable iff (!rstN)
      doneVec[g] |-> outstanding[g]);
  end

  assert_self_field_R1: assert property (@(posedge clk) disable iff (!rstN)
    anyDone |-> selfField == respState);

  assert_lone_modified_R6: assert property (@(posedge clk) disable iff (!rstN)
    (anyDone && modCount > 0) |-> (modCount == 1 && liveCount == 1));

  assert_read_miss_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    (anyDone && doneOp == 2'd0 && !respHit) |-> (respState == 2'd1 || respState == 2'd2));

  assert_write_modified_R4: assert property (@(posedge clk) disable iff (!rstN)
    (anyDone && doneOp == 2'd1) |-> respState == 2'd3);

  assert_evict_invalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (anyDone && doneOp == 2'd2) |-> (respState == 2'd0 && respData == '0));
endmodule

bind mesi_coherence mesi_checker #(.NCORES(NCORES), .DW(DW)) u_checker (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .doneVec(doneVec), .respHit(respHit), .respState(respState),
  .respData(respData), .peerStates(peerStates)
);

// File: tb/mesi_coherence_tb.sv
module mesi_coherence_tb;
  localparam int NC = 4;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EV = 2'd2;
  localparam logic [1:0] SI = 2'd0, SS = 2'd1, SE = 2'd2, SM = 2'd3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NC-1:0]     reqValid = '0;
  logic [2*NC-1:0]   reqOp = '0;
  logic [NC*AW-1:0]  reqAddr = '0;
  logic [NC*DW-1:0]  reqData = '0;
  logic [NC-1:0]     doneVec;
  logic              respHit;
  logic [1:0]        respState;
  logic [DW-1:0]     respData;
  logic [2*NC-1:0]   peerStates;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  typedef struct {
    logic           hit;
    logic [1:0]     st;
    logic [DW-1:0]  data;
    logic [2*NC-1:0] peers;
    string          rq;
  } exp_t;
  exp_t sbq [NC][$];

  always #2.5 clk = ~clk;

  mesi_coherence u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqAddr(reqAddr), .reqData(reqData), .doneVec(doneVec),
    .respHit(respHit), .respState(respState), .respData(respData),
    .peerStates(peerStates)
  );

  task automatic check(string rq, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // driver: arm one core's request and queue its expected response
  task automatic arm(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                     logic hit, logic [1:0] st, logic [DW-1:0] data,
                     logic [2*NC-1:0] peers, string rq);
    exp_t e;
    e.hit = hit; e.st = st; e.data = data; e.peers = peers; e.rq = rq;
    sbq[c].push_back(e);
    reqValid[c]          = 1'b1;
    reqOp[2*c +: 2]      = op;
    reqAddr[c*AW +: AW]  = a;
    reqData[c*DW +: DW]  = d;
  endtask

  task automatic quiet(output int waited);
    waited = 0;
    while (sbq[0].size() + sbq[1].size() + sbq[2].size() + sbq[3].size() != 0) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic issue(int c, logic [1:0] op, logic [AW-1:0] a, logic [DW-1:0] d,
                       logic hit, logic [1:0] st, logic [DW-1:0] data,
                       logic [2*NC-1:0] peers, string rq);
    int w;
    @(negedge clk);
    arm(c, op, a, d, hit, st, data, peers, rq);
    @(negedge clk);
    reqValid = '0;
    quiet(w);
  endtask

  // monitor: pop and compare on each completion
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NC; c++) begin
        if (doneVec[c]) begin
          if (sbq[c].size() == 0) begin
            check("R10", "unexpected done", 32'(c), 32'hFFFF_FFFF);
          end else begin
            exp_t e;
            e = sbq[c].pop_front();
            check(e.rq, "hit",   32'(respHit),    32'(e.hit));
            check(e.rq, "state", 32'(respState),  32'(e.st));
            check(e.rq, "data",  respData,        e.data);
            check(e.rq, "peers", 32'(peerStates), 32'(e.peers));
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
    end
  end

  initial begin
    int w;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset leaves outputs idle and all lines Invalid
    check("R1", "done after reset",  32'(doneVec),    32'h0);
    check("R1", "state after reset", 32'(respState),  32'h0);
    check("R1", "peers after reset", 32'(peerStates), 32'h0);

    issue(0, RD, 8'h10, 0, 0, SE, 32'h0, 8'h02, "R2");
    issue(1, RD, 8'h10, 0, 0, SS, 32'h0, 8'h05, "R3");
    issue(1, WR, 8'h11, 32'hAAAA, 1, SM, 32'hAAAA, 8'h0C, "R4");
    issue(0, RD, 8'h11, 0, 0, SS, 32'hAAAA, 8'h05, "R8");
    issue(2, WR, 8'h12, 32'hBBBB, 0, SM, 32'hBBBB, 8'h30, "R9");
    issue(3, RD, 8'h20, 0, 0, SE, 32'h0, 8'h80, "R2");
    issue(3, WR, 8'h20, 32'h1234, 1, SM, 32'h1234, 8'hC0, "R5");
    issue(3, EV, 8'h20, 0, 1, SI, 32'h0, 8'h00, "R7");
    issue(0, RD, 8'h20, 0, 0, SE, 32'h1234, 8'h02, "R7");
    // dirty victim plus remote Modified supplier in one commit
    issue(0, WR, 8'h53, 32'hCCCC, 0, SM, 32'hCCCC, 8'h03, "R6");
    issue(0, RD, 8'h12, 0, 0, SS, 32'hBBBB, 8'h11, "R13");
    issue(1, RD, 8'h53, 0, 0, SE, 32'hCCCC, 8'h08, "R13");
    issue(3, RD, 8'h12, 0, 0, SS, 32'hBBBB, 8'h51, "R8");
    issue(0, EV, 8'h12, 0, 1, SI, 32'h0, 8'h50, "R7");
    issue(3, RD, 8'h11, 0, 1, SS, 32'hAAAA, 8'h50, "R11");

    // R10: four requests raised in the same cycle
    @(negedge clk);
    arm(0, RD, 8'h30, 0, 0, SE, 32'h0, 8'h02, "R10");
    arm(1, RD, 8'h70, 0, 0, SE, 32'h0, 8'h08, "R10");
    arm(2, RD, 8'hB0, 0, 0, SE, 32'h0, 8'h20, "R10");
    arm(3, RD, 8'hF0, 0, 0, SE, 32'h0, 8'h80, "R10");
    @(negedge clk);
    reqValid = '0;
    quiet(w);
    check("R10", "cycles to serve four", 32'(w <= 9), 32'h1);

    issue(1, EV, 8'hF4, 0, 0, SI, 32'h0, 8'h80, "R12");
    issue(1, RD, 8'h70, 0, 1, SE, 32'h0, 8'h08, "R12");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    summary();
  end
endmodule